// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the byte that a banked NOR-style flash device puts on its data bus when software reads it while a program or erase is running, together with the device's ready/busy level. The command decoder and the embedded algorithms around it supply the current operation, the bank that is busy, the set of sectors being erased (or held in suspend), the sector-timer bit and a pulse-limit flag. Array storage supplies the stored byte for the read address.

On each read strobe the block decodes the read address into a bank and a sector. If that location is taken up by the running operation, the block returns a status byte. Otherwise it passes the array byte through. The status byte carries the complement of the written data's top bit. It also carries two toggle bits, which flip on successive status reads, a sticky timing-fault bit and the sector-timer bit. Software polls it to follow progress, to find which sectors are under erase, and to see when an operation has failed. The read value is registered and holds between strobes.

Top module: `flash_wsg`

## Requirements
- R1: With the operation code `op_mode` = 0 (idle), or when the read bank (`rd_addr[11:10]`) differs from `busy_bank`, a read strobe returns `arr_data` on `dq_out`. Any `op_mode` value of 5 to 7 is treated as idle.
- R2: With `op_mode` = 1 (program) and the read bank equal to `busy_bank`, a read returns bit 7 = NOT `prog_data[7]`, bit 6 = the bit-6 toggle, bit 5 = the fault flag, and bits 4..0 = 0. `ready` is 0.
- R3: With `op_mode` = 2 (erase) and the bank busy, a read returns bit 7 = 0, bit 6 = the bit-6 toggle, bit 5 = the fault flag, bit 3 = `sector_timer`, and bit 2 = the bit-2 toggle. Bit 2 follows the toggle only when `erase_set[rd_addr[11:8]]` is 1 and is 0 otherwise. Bits 4, 1 and 0 are 0, and `ready` is 0.
- R4: With `op_mode` = 3 (suspended erase, reading) and the addressed sector marked in `erase_set` within the busy bank, a read returns bit 7 = 1 and bit 2 = the bit-2 toggle, with every other bit 0. `ready` is 1.
- R5: With `op_mode` = 3 and the addressed sector not in `erase_set`, or the bank not busy, a read returns `arr_data`. `ready` is 1.
- R6: With `op_mode` = 4 (program inside a suspended erase) and the bank busy, a read returns bit 7 = NOT `prog_data[7]`, bit 6 = the bit-6 toggle, bit 5 = the fault flag, and bits 4..0 = 0. This holds even for sectors in `erase_set`. `ready` is 0.
- R7: The bit-6 toggle inverts after each status read that shows it. The bit-2 toggle inverts after each status read that shows it. Array reads advance neither toggle.
- R8: `limit_hit` sampled high while `op_mode` is 1, 2 or 4 sets the fault flag. The flag stays set after `limit_hit` falls and clears only on a `cmd_reset` pulse. `limit_hit` has no effect in modes 0 and 3.
- R9: After reset, `dq_out` = 0, `ready` = 1 and both toggles are 0. `dq_out` changes only on the clock edge that samples `rd_strobe` high.
- R10: `ready` is registered. It is 0 from the first edge after `op_mode` enters 1, 2 or 4, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Operation code: 0 idle, 1 program, 2 erase, 3 suspended-erase read, 4 suspended-erase program |
| busy_bank | input | 2 | Bank holding the running operation |
| rd_strobe | input | 1 | One-cycle read request |
| rd_addr | input | 12 | Read address; bits 11:8 select the sector, bits 11:10 the bank |
| arr_data | input | 8 | Stored byte at the read address |
| prog_data | input | 8 | Byte being programmed |
| erase_set | input | 16 | One bit per sector: selected for erase, or suspended |
| sector_timer | input | 1 | Sector-erase timer bit, shown as bit 3 during erase |
| limit_hit | input | 1 | Pulse-count limit exceeded by the running algorithm |
| cmd_reset | input | 1 | Reset command; clears the fault flag |
| dq_out | output | 8 | Registered read byte |
| ready | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest condition to reach from the ports is a history-dependent toggle value, such as a bit-2 read in erase after an unselected-sector read and an array read have come in between. The value then depends on exactly which earlier strobes returned status. The stimulus table interleaves these kinds of reads in one run without a reset. The bench keeps its own toggle model, which advances only when an expected value shows the toggle, so a toggle that advances on the wrong read shifts every later expectation. A separate sequence makes the fault flag sticky: it pulses `limit_hit` with no strobe, reads twice, then clears the flag with `cmd_reset`.

// File: rtl/flash_wsg_pkg.sv
package flash_wsg_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_PROG    = 3'd1,
        OP_ERASE   = 3'd2,
        OP_SUSP_RD = 3'd3,
        OP_SUSP_PG = 3'd4
    } op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dq;
        logic              ready;
        logic              fault;
        logic              tog6;
        logic              tog2;
    } wsg_state_t;

    function automatic logic op_busy(input op_e op);
        return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SUSP_PG);
    endfunction

endpackage

// File: rtl/flash_wsg_decode.sv
module flash_wsg_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned SECT_W = 4,
    localparam int unsigned NSECT = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BANK_W-1:0] busy_bank,
    input  logic [NSECT-1:0]  erase_set,
    output logic              bank_hit,
    output logic              in_set
);

    logic [SECT_W-1:0] sector_idx;
    logic [BANK_W-1:0] bank_idx;

    assign sector_idx = rd_addr[ADDR_W-1 -: SECT_W];
    assign bank_idx   = rd_addr[ADDR_W-1 -: BANK_W];
    assign bank_hit   = (bank_idx == busy_bank);
    assign in_set     = erase_set[sector_idx];

endmodule

// File: rtl/flash_wsg_mux.sv
module flash_wsg_mux
    import flash_wsg_pkg::*;
(
    input  op_e               op,
    input  logic              bank_hit,
    input  logic              in_set,
    input  logic              prog_top,
    input  logic              timer_bit,
    input  logic              fault,
    input  logic              tog6,
    input  logic              tog2,
    input  logic [BYTE_W-1:0] arr_data,
    output logic [BYTE_W-1:0] rd_val,
    output logic              adv6,
    output logic              adv2
);

    always_comb begin
        rd_val = arr_data;
        adv6   = 1'b0;
        adv2   = 1'b0;
        case (op)
            OP_PROG, OP_SUSP_PG: begin
                if (bank_hit) begin
                    rd_val = {~prog_top, tog6, fault, 5'b00000};
                    adv6   = 1'b1;
                end
            end
            OP_ERASE: begin
                if (bank_hit) begin
                    rd_val = {1'b0, tog6, fault, 1'b0, timer_bit,
                              (in_set & tog2), 2'b00};
                    adv6   = 1'b1;
                    adv2   = in_set;
                end
            end
            OP_SUSP_RD: begin
                if (bank_hit && in_set) begin
                    rd_val = {1'b1, 4'b0000, tog2, 2'b00};
                    adv2   = 1'b1;
                end
            end
            default: begin
                rd_val = arr_data;
            end
        endcase
    end

endmodule

// File: rtl/flash_wsg.sv
module flash_wsg
    import flash_wsg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned SECT_W = 4,
    localparam int unsigned NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic [BANK_W-1:0] busy_bank,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_data,
    input  logic [7:0]        prog_data,
    input  logic [NSECT-1:0]  erase_set,
    input  logic              sector_timer,
    input  logic              limit_hit,
    input  logic              cmd_reset,
    output logic [7:0]        dq_out,
    output logic              ready
);

    op_e        op;
    wsg_state_t state_d, state_q;
    logic       bank_hit, in_set, adv6, adv2;
    logic [7:0] rd_val;
    logic       fault_q, tog6_q, tog2_q;

    assign op = op_e'(op_mode);

    flash_wsg_decode #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .SECT_W (SECT_W)
    ) u_decode (
        .rd_addr   (rd_addr),
        .busy_bank (busy_bank),
        .erase_set (erase_set),
        .bank_hit  (bank_hit),
        .in_set    (in_set)
    );

    flash_wsg_mux u_mux (
        .op        (op),
        .bank_hit  (bank_hit),
        .in_set    (in_set),
        .prog_top  (prog_data[7]),
        .timer_bit (sector_timer),
        .fault     (state_q.fault),
        .tog6      (state_q.tog6),
        .tog2      (state_q.tog2),
        .arr_data  (arr_data),
        .rd_val    (rd_val),
        .adv6      (adv6),
        .adv2      (adv2)
    );

    always_comb begin
        state_d       = state_q;
        state_d.ready = ~op_busy(op);
        if (cmd_reset) begin
            state_d.fault = 1'b0;
        end else if (limit_hit && op_busy(op)) begin
            state_d.fault = 1'b1;
        end
        if (rd_strobe) begin
            state_d.dq = rd_val;
            if (adv6) state_d.tog6 = ~state_q.tog6;
            if (adv2) state_d.tog2 = ~state_q.tog2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{dq: '0, ready: 1'b1, fault: 1'b0, tog6: 1'b0, tog2: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign dq_out  = state_q.dq;
    assign ready   = state_q.ready;
    assign fault_q = state_q.fault;
    assign tog6_q  = state_q.tog6;
    assign tog2_q  = state_q.tog2;

endmodule

// File: rtl/flash_wsg_chk.sv
module flash_wsg_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned SECT_W = 4,
    localparam int unsigned NSECT = 1 << SECT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_mode,
    input logic [BANK_W-1:0] busy_bank,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        prog_data,
    input logic [NSECT-1:0]  erase_set,
    input logic              cmd_reset,
    input logic [7:0]        dq_out,
    input logic              ready,
    input logic              fault_q,
    input logic              tog6_q,
    input logic              tog2_q
);

    logic hit, sel;
    assign hit = (rd_addr[ADDR_W-1 -: BANK_W] == busy_bank);
    assign sel = erase_set[rd_addr[ADDR_W-1 -: SECT_W]];

    a_r9_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(dq_out));

    a_r7_toggles_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ($stable(tog6_q) && $stable(tog2_q)));

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !cmd_reset) |=> fault_q);

    a_r8_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !fault_q);

    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd1 || op_mode == 3'd2 || op_mode == 3'd4) |=> !ready);

    a_r2_prog_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_mode == 3'd1 && hit) |=>
        (dq_out[7] == !$past(prog_data[7]) && dq_out[4:0] == 5'b0));

    a_r3_unsel_no_bit2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_mode == 3'd2 && hit && !sel) |=> (dq_out[2] == 1'b0 && dq_out[7] == 1'b0));

    a_r4_susp_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_mode == 3'd3 && hit && sel) |=>
        (dq_out[7] && dq_out[6:3] == 4'b0 && ready));

endmodule

bind flash_wsg flash_wsg_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .SECT_W (SECT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_mode      (op_mode),
    .busy_bank    (busy_bank),
    .rd_strobe    (rd_strobe),
    .rd_addr      (rd_addr),
    .prog_data    (prog_data),
    .erase_set    (erase_set),
    .cmd_reset    (cmd_reset),
    .dq_out       (dq_out),
    .ready        (ready),
    .fault_q      (fault_q),
    .tog6_q       (tog6_q),
    .tog2_q       (tog2_q)
);

// File: tb/flash_wsg_tb_top.sv
module flash_wsg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_mode = 3'd0;
    logic [1:0]  busy_bank = 2'd0;
    logic        rd_strobe = 1'b0;
    logic [11:0] rd_addr = 12'h000;
    logic [7:0]  arr_data = 8'h3C;
    logic [7:0]  prog_data = 8'hA5;
    logic [15:0] erase_set = 16'h0012;
    logic        sector_timer = 1'b0;
    logic        limit_hit = 1'b0;
    logic        cmd_reset = 1'b0;
    logic [7:0]  dq_out;
    logic        ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    flash_wsg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_mode      (op_mode),
        .busy_bank    (busy_bank),
        .rd_strobe    (rd_strobe),
        .rd_addr      (rd_addr),
        .arr_data     (arr_data),
        .prog_data    (prog_data),
        .erase_set    (erase_set),
        .sector_timer (sector_timer),
        .limit_hit    (limit_hit),
        .cmd_reset    (cmd_reset),
        .dq_out       (dq_out),
        .ready        (ready)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [11:0] addr;
        logic [7:0]  prog;
        logic        timer;
        logic [7:0]  base;
        logic        u6;
        logic        u2;
        logic        rdy;
    } vec_t;

    // busy bank is 0 throughout; erase_set marks sectors 1 and 4; arr_data = 3C
    localparam vec_t VEC [0:14] = '{
        '{3'd0, 12'h100, 8'hA5, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1},
        '{3'd1, 12'h000, 8'hA5, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{3'd1, 12'h000, 8'hA5, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{3'd1, 12'h000, 8'h35, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0},
        '{3'd1, 12'h800, 8'h35, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0},
        '{3'd2, 12'h100, 8'h35, 1'b1, 8'h08, 1'b1, 1'b1, 1'b0},
        '{3'd2, 12'h100, 8'h35, 1'b1, 8'h08, 1'b1, 1'b1, 1'b0},
        '{3'd2, 12'h000, 8'h35, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{3'd2, 12'h400, 8'h35, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0},
        '{3'd3, 12'h100, 8'h35, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1},
        '{3'd3, 12'h100, 8'h35, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1},
        '{3'd3, 12'h000, 8'h35, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1},
        '{3'd4, 12'h000, 8'h35, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0},
        '{3'd4, 12'h100, 8'h35, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0},
        '{3'd4, 12'h800, 8'h35, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0}
    };

    localparam string VREQ [0:14] = '{"R1", "R2", "R2", "R2", "R1", "R3", "R3", "R3",
                                      "R1", "R4", "R4", "R5", "R6", "R6", "R1"};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] base, input logic u6, input logic u2,
                           input logic rdy, input string req);
        logic [7:0] exp;
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        exp = base | (u6 ? {1'b0, m6, 6'b0} : 8'h00) | (u2 ? {5'b0, m2, 2'b0} : 8'h00);
        check(req, dq_out, exp);
        check({req, " ready"}, {7'b0, ready}, {7'b0, rdy});
        if (u6) m6 = ~m6;
        if (u2) m2 = ~m2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset dq", dq_out, 8'h00);
        check("R9 reset ready", {7'b0, ready}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 15; i++) begin
            op_mode      = VEC[i].mode;
            rd_addr      = VEC[i].addr;
            prog_data    = VEC[i].prog;
            sector_timer = VEC[i].timer;
            do_read(VEC[i].base, VEC[i].u6, VEC[i].u2, VEC[i].rdy, VREQ[i]);
        end

        // R9: output holds without a strobe
        held = dq_out;
        arr_data = 8'h5A;
        op_mode  = 3'd0;
        repeat (3) @(negedge clk);
        check("R9 hold", dq_out, held);

        // R10: ready registered, one edge of latency
        op_mode = 3'd1;
        #1;
        check("R10 before edge", {7'b0, ready}, 8'h01);
        @(negedge clk);
        check("R10 after edge", {7'b0, ready}, 8'h00);

        // R8: limit ignored while idle
        op_mode = 3'd0;
        limit_hit = 1'b1;
        @(negedge clk);
        limit_hit = 1'b0;
        op_mode = 3'd1;
        rd_addr = 12'h000;
        prog_data = 8'h35;
        do_read(8'h80, 1'b1, 1'b0, 1'b0, "R8 idle limit ignored");

        // R8: sticky fault during program
        limit_hit = 1'b1;
        @(negedge clk);
        limit_hit = 1'b0;
        do_read(8'hA0, 1'b1, 1'b0, 1'b0, "R8 fault set");
        do_read(8'hA0, 1'b1, 1'b0, 1'b0, "R8 fault held");
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        do_read(8'h80, 1'b1, 1'b0, 1'b0, "R8 fault cleared");

        // R7: array reads leave toggles unchanged, then bit 2 resumes in erase
        op_mode = 3'd2;
        sector_timer = 1'b1;
        rd_addr = 12'hC00;
        do_read(8'h5A, 1'b0, 1'b0, 1'b0, "R7 array read");
        rd_addr = 12'h100;
        do_read(8'h08, 1'b1, 1'b1, 1'b0, "R7 erase after array");

        // R9: reset clears toggles
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m6 = 1'b0;
        m2 = 1'b0;
        op_mode = 3'd1;
        rd_addr = 12'h000;
        @(negedge clk);
        do_read(8'h80, 1'b1, 1'b0, 1'b0, "R9 toggle after reset");
        do_read(8'h80, 1'b1, 1'b0, 1'b0, "R9 toggle second");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule